// File: doc/BRIEF.md
# Square Tone Period Sweep Unit

This block owns the 11-bit period register of a square-wave tone channel. At a rate set in its control byte it moves that period: it shifts the live period right by a programmed amount and then either adds the shifted value to the period or subtracts it. A tone timer elsewhere reads the live period. The block also raises a mute flag that the channel mixer uses to silence the tone.

The control byte is written through a one-cycle strobe. A frame sequencer elsewhere supplies a half-frame tick. The block also has a direct period write port and receives the channel's length-counter-nonzero flag. The parameter `VARIANT` selects one of two subtraction styles. Variant 1 subtracts with one's complement and so takes one extra unit off. Variant 2 subtracts with two's complement.

Top module: `tone_sweep`

## Requirements
- R1: Reset clears the period to 0, the control fields to 0 and the rate divider to 0. With a period of 0 the mute flag reads 1.
- R2: Bit 3 of the control byte selects the direction, where 0 means increase. In increase mode a step sets the period to period + (period >> S). S is control bits 2..0.
- R3: In decrease mode (bit 3 = 1), variant 2 sets the period to period - (period >> S). Variant 1 sets it to period - (period >> S) - 1.
- R4: A step changes the period only when all three of these hold: control bit 7 (enable) is 1, S is nonzero, and lengthActive is 1. Otherwise the period holds its value.
- R5: With control bits 6..4 equal to N, a step happens on every (N+1)-th half-frame tick, counted from the last control write.
- R6: When the period is below 8, mute is 1 and no step changes the period. This holds whether or not sweeping is enabled.
- R7: In increase mode, mute is 1 and no step changes the period when period + (period >> S) carries out of bit 10. This holds whether or not sweeping is enabled.
- R8: A period write shows on the period output on the next cycle. It wins over a step in the same cycle, and later steps start from the written value.
- R9: A control write reloads the rate divider from the new N. A tick in the same cycle as the write is not counted.
- R10: Without a half-frame tick or a period write, the period never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWe | input | 1 | Control byte write strobe |
| ctrlData | input | 8 | Control byte: enable, rate, direction, shift |
| halfTick | input | 1 | Half-frame tick, one cycle wide |
| periodWe | input | 1 | Period write strobe |
| periodIn | input | 11 | Period value to write |
| lengthActive | input | 1 | Channel length counter is nonzero |
| period | output | 11 | Live channel period |
| mute | output | 1 | Sweep-requested silence |

## Verification
The assertions check on every cycle that the period stays frozen when there is no tick or no write, when lengthActive is low, and while mute is set. They also check that a period write lands on the next cycle, that a period below 8 forces mute, and that reset clears the period. Only the bench scenarios can show the arithmetic of a step in each direction and for each variant, the overflow mute, the spacing of steps in ticks, and the divider reload on a control write. These depend on the control byte's contents and on history over several ticks.

// File: rtl/tone_sweep_pkg.sv
package tone_sweep_pkg;
  localparam int SHIFT_W = 3;
  localparam int RATE_W  = 3;
  localparam int CTRL_W  = 8;

  typedef struct packed {
    logic               step;
    logic               enable;
    logic               dirDown;
    logic [SHIFT_W-1:0] shiftAmt;
  } sweepCmd_t;
endpackage

// File: rtl/tone_sweep_ctrl.sv
module tone_sweep_ctrl
  import tone_sweep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              halfTick,
  output sweepCmd_t         cmd
);
  localparam int SHIFT_LSB = 0;
  localparam int DIR_BIT   = SHIFT_LSB + SHIFT_W;
  localparam int RATE_LSB  = DIR_BIT + 1;
  localparam int EN_BIT    = RATE_LSB + RATE_W;

  logic               enQ;
  logic               dirQ;
  logic [RATE_W-1:0]  rateQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic [RATE_W-1:0]  divQ;
  logic               divZero;

  assign divZero = (divQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      dirQ   <= 1'b0;
      rateQ  <= '0;
      shiftQ <= '0;
    end else if (ctrlWe) begin
      enQ    <= ctrlData[EN_BIT];
      dirQ   <= ctrlData[DIR_BIT];
      rateQ  <= ctrlData[RATE_LSB +: RATE_W];
      shiftQ <= ctrlData[SHIFT_LSB +: SHIFT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
    end else if (ctrlWe) begin
      divQ <= ctrlData[RATE_LSB +: RATE_W];
    end else if (halfTick) begin
      if (divZero) divQ <= rateQ;
      else         divQ <= divQ - 1'b1;
    end
  end

  always_comb begin
    cmd.step     = halfTick & ~ctrlWe & divZero;
    cmd.enable   = enQ;
    cmd.dirDown  = dirQ;
    cmd.shiftAmt = shiftQ;
  end
endmodule

// File: rtl/tone_sweep_dp.sv
module tone_sweep_dp
  import tone_sweep_pkg::*;
#(
  parameter int PERIOD_W   = 11,
  parameter int VARIANT    = 2,
  parameter int MIN_PERIOD = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  sweepCmd_t           cmd,
  input  logic                periodWe,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic                lengthActive,
  output logic [PERIOD_W-1:0] period,
  output logic                mute
);
  localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);

  logic [PERIOD_W-1:0] periodQ;
  logic [PERIOD_W-1:0] shifted;
  logic [PERIOD_W:0]   sum;
  logic [PERIOD_W-1:0] diff;
  logic                tooLow;
  logic                overflow;
  logic                doStep;

  assign shifted = periodQ >> cmd.shiftAmt;
  assign sum     = {1'b0, periodQ} + {1'b0, shifted};

  generate
    if (VARIANT == 1) begin : g_onesComp
      assign diff = periodQ + ~shifted;
    end else begin : g_twosComp
      assign diff = periodQ - shifted;
    end
  endgenerate

  assign tooLow   = (periodQ < MIN_P);
  assign overflow = ~cmd.dirDown & sum[PERIOD_W];
  assign mute     = tooLow | overflow;
  assign doStep   = cmd.step & cmd.enable & (cmd.shiftAmt != '0) & lengthActive & ~mute;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         periodQ <= '0;
    else if (periodWe) periodQ <= periodIn;
    else if (doStep)   periodQ <= cmd.dirDown ? diff : sum[PERIOD_W-1:0];
  end

  assign period = periodQ;
endmodule

// File: rtl/tone_sweep.sv
module tone_sweep
  import tone_sweep_pkg::*;
#(
  parameter int PERIOD_W   = 11,
  parameter int VARIANT    = 2,
  parameter int MIN_PERIOD = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWe,
  input  logic [CTRL_W-1:0]   ctrlData,
  input  logic                halfTick,
  input  logic                periodWe,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic                lengthActive,
  output logic [PERIOD_W-1:0] period,
  output logic                mute
);
  sweepCmd_t cmd;

  tone_sweep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .halfTick(halfTick), .cmd(cmd)
  );

  tone_sweep_dp #(.PERIOD_W(PERIOD_W), .VARIANT(VARIANT), .MIN_PERIOD(MIN_PERIOD)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .periodWe(periodWe), .periodIn(periodIn),
    .lengthActive(lengthActive), .period(period), .mute(mute)
  );
endmodule

// File: rtl/tone_sweep_chk.sv
module tone_sweep_chk #(
  parameter int PERIOD_W   = 11,
  parameter int MIN_PERIOD = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                halfTick,
  input logic                periodWe,
  input logic [PERIOD_W-1:0] periodIn,
  input logic                lengthActive,
  input logic [PERIOD_W-1:0] period,
  input logic                mute
);
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> period == '0);

  p_length_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!lengthActive && !periodWe) |=> $stable(period));

  p_low_mutes_r6: assert property (@(posedge clk) disable iff (!rstN)
    (period < PERIOD_W'(MIN_PERIOD)) |-> mute);

  p_muted_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mute && !periodWe) |=> $stable(period));

  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    periodWe |=> period == $past(periodIn));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!halfTick && !periodWe) |=> $stable(period));
endmodule

bind tone_sweep tone_sweep_chk #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk(clk), .rstN(rstN), .halfTick(halfTick), .periodWe(periodWe),
  .periodIn(periodIn), .lengthActive(lengthActive), .period(period), .mute(mute)
);

// File: tb/tone_sweep_tb_top.sv
module tone_sweep_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [10:0] start;
    logic        len;
    logic [10:0] exp2;
    logic [10:0] exp1;
    logic        expMute;
  } vec_t;

  // R2 inc, R3 dec per variant, R4 gating, R6 low period, R7 carry
  localparam vec_t VECS [10] = '{
    '{8'h81, 11'h100, 1'b1, 11'h180, 11'h180, 1'b0},  // R2
    '{8'h8A, 11'h200, 1'b1, 11'h180, 11'h17F, 1'b0},  // R3
    '{8'hA9, 11'h0FF, 1'b1, 11'h080, 11'h07F, 1'b0},  // R3 R5
    '{8'h93, 11'h3E8, 1'b1, 11'h465, 11'h465, 1'b0},  // R2 R5
    '{8'h80, 11'h300, 1'b1, 11'h300, 11'h300, 1'b0},  // R4 shift 0
    '{8'h81, 11'h100, 1'b0, 11'h100, 11'h100, 1'b0},  // R4 length 0
    '{8'h81, 11'h700, 1'b1, 11'h700, 11'h700, 1'b1},  // R7
    '{8'h01, 11'h700, 1'b1, 11'h700, 11'h700, 1'b1},  // R7 disabled
    '{8'h89, 11'h005, 1'b1, 11'h005, 11'h005, 1'b1},  // R6
    '{8'h09, 11'h700, 1'b1, 11'h700, 11'h700, 1'b0}   // R4 disabled
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0;
  logic [7:0] ctrlData = '0;
  logic halfTick = 1'b0;
  logic periodWe = 1'b0;
  logic [10:0] periodIn = '0;
  logic lengthActive = 1'b1;
  logic [10:0] period2, period1;
  logic mute2, mute1;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_sweep #(.VARIANT(2)) dut_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData), .halfTick(halfTick),
    .periodWe(periodWe), .periodIn(periodIn), .lengthActive(lengthActive),
    .period(period2), .mute(mute2)
  );

  tone_sweep #(.VARIANT(1)) dut1_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData), .halfTick(halfTick),
    .periodWe(periodWe), .periodIn(periodIn), .lengthActive(lengthActive),
    .period(period1), .mute(mute1)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlData = v;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic writePeriod(input logic [10:0] v);
    @(negedge clk); periodWe = 1'b1; periodIn = v;
    @(negedge clk); periodWe = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); halfTick = 1'b1;
    @(negedge clk); halfTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 period", {1'b0, period2}, 12'h000);
    chk("R1 mute", {11'b0, mute2}, 12'h001);
    rstN = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      lengthActive = VECS[i].len;
      writePeriod(VECS[i].start);
      writeCtrl(VECS[i].ctrl);
      chk("R6 R7 mute before step", {11'b0, mute2}, {11'b0, VECS[i].expMute});
      for (int k = 0; k < int'(VECS[i].ctrl[6:4]); k++) tick();
      chk("R5 no early step", {1'b0, period2}, {1'b0, VECS[i].start});
      repeat (4) @(negedge clk);
      chk("R10 idle hold", {1'b0, period2}, {1'b0, VECS[i].start});
      tick();
      chk("R2 R3 R4 variant2", {1'b0, period2}, {1'b0, VECS[i].exp2});
      chk("R3 variant1", {1'b0, period1}, {1'b0, VECS[i].exp1});
      chk("R6 R7 mute variant1", {11'b0, mute1}, {11'b0, VECS[i].expMute});
    end
    lengthActive = 1'b1;

    // R8: write wins over a same-cycle step, next step starts from it
    writePeriod(11'h100);
    writeCtrl(8'h81);
    @(negedge clk); periodWe = 1'b1; periodIn = 11'h050; halfTick = 1'b1;
    @(negedge clk); periodWe = 1'b0; halfTick = 1'b0;
    chk("R8 write wins", {1'b0, period2}, 12'h050);
    tick();
    chk("R8 step from written", {1'b0, period2}, 12'h078);

    // R9: control rewrite reloads divider
    writePeriod(11'h100);
    writeCtrl(8'hB1);
    tick(); tick();
    writeCtrl(8'hB1);
    tick(); tick(); tick();
    chk("R9 reload delays step", {1'b0, period2}, 12'h100);
    tick();
    chk("R9 step after reload", {1'b0, period2}, 12'h180);

    // R9: tick coinciding with control write is not counted
    writePeriod(11'h100);
    @(negedge clk); ctrlWe = 1'b1; ctrlData = 8'h81; halfTick = 1'b1;
    @(negedge clk); ctrlWe = 1'b0; halfTick = 1'b0;
    chk("R9 tick on write ignored", {1'b0, period2}, 12'h100);

    // R1: reset mid-run
    writePeriod(11'h3FF);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", {1'b0, period2}, 12'h000);
    chk("R1 reset mute", {11'b0, mute1}, 12'h001);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule